// File: doc/BRIEF.md
# Coarse Tile Depth Culler

This block runs the coarse pass that comes before fine rasterisation. A primitive arrives as a pixel bounding box with its nearest depth. The block visits every 4x2-pixel screen tile that the box touches, at least partly, and tests one tile per cycle. Each tile has a conservative farthest depth held in an on-block store. If the nearest depth of the primitive cannot beat that stored value, the tile is hidden for certain and is dropped, so its eight fragments are removed in one cycle. Every tile that is not dropped is sent to the fine rasteriser as a tile coordinate.

The pixel writer feeds results back through an update port. For each written tile it gives the farthest depth it wrote and says whether every pixel of the tile was covered. Only a full-coverage update may lower a stored value, so the stored value never falls below the true farthest depth of the tile. A clear input, like reset, puts every tile back at the farthest depth. Screen size in tiles, depth width and the depth comparison are parameters.

Top module: `tile_zcull`

## Requirements
- R1: After reset every tile's stored farthest depth is all ones, prim_ready is 1 and tile_valid is 0. A primitive with nearest depth below all ones therefore survives on every tile, and one at all ones is culled on every tile.
- R2: A primitive with pixel box [xmin..xmax] x [ymin..ymax], where xmin <= xmax and ymin <= ymax, tests exactly the tiles with tile_x in [xmin>>2 .. xmax>>2] and tile_y in [ymin>>1 .. ymax>>1].
- R3: Tiles are tested one per cycle in row-major order, with tile_x fastest. When acceptance happens at clock edge A, the k-th tile (counting from 0) is tested in the cycle that ends at edge A+k+1. If it survives, tile_valid=1 with its coordinates is shown for the cycle after that edge.
- R4: prim_ready is 0 from the accepting edge until the edge that ends the last test. A primitive of N tiles keeps it low for exactly N cycles.
- R5: With the default less-than depth function, a tile is culled when the primitive's nearest depth is greater than or equal to the tile's stored farthest depth. Otherwise it survives.
- R6: An update with upd_full=1 sets the tile's stored value to the smaller of the stored value and upd_zmax, starting from the next cycle.
- R7: An update with upd_full=0 leaves the stored value unchanged.
- R8: clr sets every stored value to all ones from the next cycle, and wins over an update in the same cycle.
- R9: A test and an update of the same tile in the same cycle use the stored value from before the update.
- R10: prim_valid and the box inputs are ignored while prim_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Set all tile depths to farthest |
| prim_valid | input | 1 | Primitive offered |
| prim_ready | output | 1 | Idle; primitive taken when both high |
| prim_xmin | input | 6 | Box left pixel |
| prim_xmax | input | 6 | Box right pixel |
| prim_ymin | input | 4 | Box top pixel |
| prim_ymax | input | 4 | Box bottom pixel |
| prim_zmin | input | 16 | Nearest depth of primitive |
| upd_valid | input | 1 | Depth update strobe |
| upd_full | input | 1 | All 8 pixels of the tile written |
| upd_tx | input | 4 | Update tile column |
| upd_ty | input | 3 | Update tile row |
| upd_zmax | input | 16 | Farthest depth written in the tile |
| tile_valid | output | 1 | Surviving tile present |
| tile_x | output | 4 | Surviving tile column |
| tile_y | output | 3 | Surviving tile row |

## Verification
Two events can land in the same cycle: the test of a tile and a depth update of that same tile. A clear can also arrive together with an update. The bench aims a full-coverage update at the tile under test in exactly the cycle of its test, and checks that this test still uses the old farthest depth while the next primitive over that tile sees the new one. It also issues a clear and an update together and checks that the tile comes back at farthest depth. The random phase sends updates, clears and primitive offers together during walks, and each output cycle is compared with a bench model that reads the store before applying that cycle's write.

// File: rtl/tzc_pkg.sv
package tzc_pkg;
   // depth comparison used by the incoming fragments
   typedef enum logic [0:0] {
      TZC_LESS   = 1'b0,
      TZC_LEQUAL = 1'b1
   } tzc_func_e;

   // tile footprint in pixels, as log2 shifts: 4 wide, 2 tall
   localparam int TILE_XS = 2;
   localparam int TILE_YS = 1;
endpackage

// File: rtl/tzc_walker.sv
module tzc_walker #(
   parameter int TXW = 4,
   parameter int TYW = 3,
   parameter int DW  = 16,
   localparam int PXW = TXW + tzc_pkg::TILE_XS,
   localparam int PYW = TYW + tzc_pkg::TILE_YS
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           prim_valid,
   input  logic [PXW-1:0] prim_xmin,
   input  logic [PXW-1:0] prim_xmax,
   input  logic [PYW-1:0] prim_ymin,
   input  logic [PYW-1:0] prim_ymax,
   input  logic [DW-1:0]  prim_zmin,
   output logic           walk_act,
   output logic [TXW-1:0] walk_tx,
   output logic [TYW-1:0] walk_ty,
   output logic [DW-1:0]  walk_z
);
   logic           busy;
   logic [TXW-1:0] cx, x0, x1;
   logic [TYW-1:0] cy, y1;
   logic [DW-1:0]  z;
   logic [TXW-1:0] in_x0, in_x1;
   logic [TYW-1:0] in_y0, in_y1;

   always_comb begin
      in_x0 = TXW'(prim_xmin >> tzc_pkg::TILE_XS);
      in_x1 = TXW'(prim_xmax >> tzc_pkg::TILE_XS);
      in_y0 = TYW'(prim_ymin >> tzc_pkg::TILE_YS);
      in_y1 = TYW'(prim_ymax >> tzc_pkg::TILE_YS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cx   <= '0;
         cy   <= '0;
         x0   <= '0;
         x1   <= '0;
         y1   <= '0;
         z    <= '0;
      end else if (busy) begin
         if (cx == x1) begin
            cx <= x0;
            if (cy == y1) busy <= 1'b0;
            else          cy   <= cy + 1'b1;
         end else begin
            cx <= cx + 1'b1;
         end
      end else if (prim_valid) begin
         busy <= 1'b1;
         cx   <= in_x0;
         x0   <= in_x0;
         x1   <= in_x1;
         cy   <= in_y0;
         y1   <= in_y1;
         z    <= prim_zmin;
      end
   end

   assign walk_act = busy;
   assign walk_tx  = cx;
   assign walk_ty  = cy;
   assign walk_z   = z;
endmodule

// File: rtl/tzc_depth_store.sv
module tzc_depth_store #(
   parameter int TXW = 4,
   parameter int TYW = 3,
   parameter int DW  = 16,
   localparam int IW = TXW + TYW,
   localparam int NT = 1 << IW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           upd_valid,
   input  logic           upd_full,
   input  logic [TXW-1:0] upd_tx,
   input  logic [TYW-1:0] upd_ty,
   input  logic [DW-1:0]  upd_zmax,
   input  logic [TXW-1:0] rd_tx,
   input  logic [TYW-1:0] rd_ty,
   output logic [DW-1:0]  rd_z,
   output logic [DW-1:0]  store_q [NT]
);
   logic [IW-1:0] wr_idx;
   logic [IW-1:0] rd_idx;
   logic          wr_en;

   assign wr_idx = {upd_ty, upd_tx};
   assign rd_idx = {rd_ty, rd_tx};
   assign wr_en  = upd_valid && upd_full;

   for (genvar t = 0; t < NT; t++) begin : g_tile
      logic [DW-1:0] q;
      logic          hit;
      assign hit = wr_en && (wr_idx == IW'(t)) && (upd_zmax < q);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '1;
         else if (clr) q <= '1;
         else if (hit) q <= upd_zmax;
      end
      assign store_q[t] = q;
   end

   assign rd_z = store_q[rd_idx];
endmodule

// File: rtl/tzc_test.sv
module tzc_test #(
   parameter int TXW = 4,
   parameter int TYW = 3,
   parameter int DW  = 16,
   parameter tzc_pkg::tzc_func_e FUNC = tzc_pkg::TZC_LESS
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           act,
   input  logic [TXW-1:0] tx,
   input  logic [TYW-1:0] ty,
   input  logic [DW-1:0]  prim_z,
   input  logic [DW-1:0]  tile_z,
   output logic           tile_valid,
   output logic [TXW-1:0] tile_x,
   output logic [TYW-1:0] tile_y
);
   logic hidden;

   if (FUNC == tzc_pkg::TZC_LESS) begin : g_less
      // a fragment passes only if strictly nearer than the stored value
      assign hidden = (prim_z >= tile_z);
   end else begin : g_lequal
      assign hidden = (prim_z > tile_z);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tile_valid <= 1'b0;
         tile_x     <= '0;
         tile_y     <= '0;
      end else begin
         tile_valid <= act && !hidden;
         if (act) begin
            tile_x <= tx;
            tile_y <= ty;
         end
      end
   end
endmodule

// File: rtl/tile_zcull.sv
module tile_zcull #(
   parameter int TILES_X = 16,
   parameter int TILES_Y = 8,
   parameter int DW      = 16,
   parameter tzc_pkg::tzc_func_e FUNC = tzc_pkg::TZC_LESS,
   localparam int TXW = $clog2(TILES_X),
   localparam int TYW = $clog2(TILES_Y),
   localparam int PXW = TXW + tzc_pkg::TILE_XS,
   localparam int PYW = TYW + tzc_pkg::TILE_YS,
   localparam int NT  = TILES_X * TILES_Y
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           prim_valid,
   output logic           prim_ready,
   input  logic [PXW-1:0] prim_xmin,
   input  logic [PXW-1:0] prim_xmax,
   input  logic [PYW-1:0] prim_ymin,
   input  logic [PYW-1:0] prim_ymax,
   input  logic [DW-1:0]  prim_zmin,
   input  logic           upd_valid,
   input  logic           upd_full,
   input  logic [TXW-1:0] upd_tx,
   input  logic [TYW-1:0] upd_ty,
   input  logic [DW-1:0]  upd_zmax,
   output logic           tile_valid,
   output logic [TXW-1:0] tile_x,
   output logic [TYW-1:0] tile_y
);
   if ((1 << TXW) != TILES_X || TILES_X < 2) begin : g_bad_tx
      $error("TILES_X must be a power of two of at least 2");
   end
   if ((1 << TYW) != TILES_Y || TILES_Y < 2) begin : g_bad_ty
      $error("TILES_Y must be a power of two of at least 2");
   end
   if (DW < 2 || DW > 32) begin : g_bad_dw
      $error("DW must lie in 2..32");
   end

   logic           walk_act;
   logic [TXW-1:0] walk_tx;
   logic [TYW-1:0] walk_ty;
   logic [DW-1:0]  walk_z;
   logic [DW-1:0]  rd_z;
   logic [DW-1:0]  store_q [NT];

   tzc_walker #(.TXW(TXW), .TYW(TYW), .DW(DW)) u_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .prim_valid (prim_valid),
      .prim_xmin  (prim_xmin),
      .prim_xmax  (prim_xmax),
      .prim_ymin  (prim_ymin),
      .prim_ymax  (prim_ymax),
      .prim_zmin  (prim_zmin),
      .walk_act   (walk_act),
      .walk_tx    (walk_tx),
      .walk_ty    (walk_ty),
      .walk_z     (walk_z)
   );

   tzc_depth_store #(.TXW(TXW), .TYW(TYW), .DW(DW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .upd_valid (upd_valid),
      .upd_full  (upd_full),
      .upd_tx    (upd_tx),
      .upd_ty    (upd_ty),
      .upd_zmax  (upd_zmax),
      .rd_tx     (walk_tx),
      .rd_ty     (walk_ty),
      .rd_z      (rd_z),
      .store_q   (store_q)
   );

   tzc_test #(.TXW(TXW), .TYW(TYW), .DW(DW), .FUNC(FUNC)) u_test (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (walk_act),
      .tx         (walk_tx),
      .ty         (walk_ty),
      .prim_z     (walk_z),
      .tile_z     (rd_z),
      .tile_valid (tile_valid),
      .tile_x     (tile_x),
      .tile_y     (tile_y)
   );

   assign prim_ready = !walk_act;
endmodule

// File: rtl/tzc_checker.sv
module tzc_checker #(
   parameter int TILES_X = 16,
   parameter int TILES_Y = 8,
   parameter int DW      = 16,
   localparam int TXW = $clog2(TILES_X),
   localparam int TYW = $clog2(TILES_Y),
   localparam int PXW = TXW + tzc_pkg::TILE_XS,
   localparam int PYW = TYW + tzc_pkg::TILE_YS,
   localparam int NT  = TILES_X * TILES_Y
) (
   input logic           clk,
   input logic           rst_n,
   input logic           clr,
   input logic           prim_valid,
   input logic           prim_ready,
   input logic [PXW-1:0] prim_xmin,
   input logic [PXW-1:0] prim_xmax,
   input logic [PYW-1:0] prim_ymin,
   input logic [PYW-1:0] prim_ymax,
   input logic           upd_valid,
   input logic           upd_full,
   input logic [TXW-1:0] upd_tx,
   input logic [TYW-1:0] upd_ty,
   input logic [DW-1:0]  upd_zmax,
   input logic           tile_valid,
   input logic [TXW-1:0] tile_x,
   input logic [TYW-1:0] tile_y,
   input logic [DW-1:0]  store_q [NT]
);
   logic [TXW-1:0]     bx0, bx1;
   logic [TYW-1:0]     by0, by1;
   logic [TXW+TYW-1:0] uidx;
   logic               all_far;

   assign uidx = {upd_ty, upd_tx};

   always_comb begin
      all_far = 1'b1;
      for (int i = 0; i < NT; i++) if (store_q[i] != '1) all_far = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bx0 <= '0; bx1 <= '1; by0 <= '0; by1 <= '1;
      end else if (prim_valid && prim_ready) begin
         bx0 <= TXW'(prim_xmin >> tzc_pkg::TILE_XS);
         bx1 <= TXW'(prim_xmax >> tzc_pkg::TILE_XS);
         by0 <= TYW'(prim_ymin >> tzc_pkg::TILE_YS);
         by1 <= TYW'(prim_ymax >> tzc_pkg::TILE_YS);
      end
   end

   assert_tile_in_box_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tile_valid |-> (tile_x >= bx0 && tile_x <= bx1 && tile_y >= by0 && tile_y <= by1));

   assert_out_follows_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tile_valid |-> !$past(prim_ready));

   assert_accept_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prim_valid && prim_ready) |=> !prim_ready);

   assert_full_update_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_full && !clr) |=>
         (store_q[$past(uidx)] == (($past(upd_zmax) < $past(store_q[uidx])) ?
                                   $past(upd_zmax) : $past(store_q[uidx]))));

   assert_partial_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_full && !clr) |=> (store_q[$past(uidx)] == $past(store_q[uidx])));

   assert_clear_far_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> all_far);
endmodule

bind tile_zcull tzc_checker #(.TILES_X(TILES_X), .TILES_Y(TILES_Y), .DW(DW)) u_tzc_chk (.*);

// File: tb/tile_zcull_bench.sv
module tile_zcull_bench;
   localparam int TX  = 16;
   localparam int TY  = 8;
   localparam int DW  = 16;
   localparam int NT  = TX * TY;
   localparam int FAR = 65535;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       prim_valid = 1'b0;
   logic       prim_ready;
   logic [5:0] prim_xmin = '0, prim_xmax = '0;
   logic [3:0] prim_ymin = '0, prim_ymax = '0;
   logic [15:0] prim_zmin = '0;
   logic       upd_valid = 1'b0, upd_full = 1'b0;
   logic [3:0] upd_tx = '0;
   logic [2:0] upd_ty = '0;
   logic [15:0] upd_zmax = '0;
   logic       tile_valid;
   logic [3:0] tile_x;
   logic [2:0] tile_y;

   always #2.5 clk = ~clk;

   tile_zcull u_tile_zcull (.*);

   int    n_vec = 0, n_bad = 0;
   string tag = "R1";

   int m_dep [NT];
   bit m_busy = 0;
   int m_cx, m_cy, m_x0, m_x1, m_y1, m_z;

   task automatic cmp(string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // one clock: model predicts from the current inputs, then outputs are compared
   task automatic cyc();
      bit ev = 0;
      int etx = 0, ety = 0;
      cmp("prim_ready", int'(prim_ready), m_busy ? 0 : 1);
      if (m_busy) begin
         ev  = !(m_z >= m_dep[m_cy*TX + m_cx]);
         etx = m_cx;
         ety = m_cy;
         if (m_cx == m_x1) begin
            m_cx = m_x0;
            if (m_cy == m_y1) m_busy = 0;
            else              m_cy++;
         end else m_cx++;
      end else if (prim_valid) begin
         m_busy = 1;
         m_x0 = int'(prim_xmin) >> 2; m_cx = m_x0;
         m_x1 = int'(prim_xmax) >> 2;
         m_cy = int'(prim_ymin) >> 1;
         m_y1 = int'(prim_ymax) >> 1;
         m_z  = int'(prim_zmin);
      end
      if (clr) begin
         for (int i = 0; i < NT; i++) m_dep[i] = FAR;
      end else if (upd_valid && upd_full) begin
         if (int'(upd_zmax) < m_dep[upd_ty*TX + upd_tx]) m_dep[upd_ty*TX + upd_tx] = int'(upd_zmax);
      end
      @(posedge clk);
      @(negedge clk);
      cmp("tile_valid", int'(tile_valid), int'(ev));
      if (ev) begin
         cmp("tile_x", int'(tile_x), etx);
         cmp("tile_y", int'(tile_y), ety);
      end
   endtask

   task automatic offer(int x0, int x1, int y0, int y1, int z);
      prim_valid = 1'b1;
      prim_xmin = 6'(x0); prim_xmax = 6'(x1);
      prim_ymin = 4'(y0); prim_ymax = 4'(y1);
      prim_zmin = 16'(z);
   endtask

   task automatic run_prim(int x0, int x1, int y0, int y1, int z);
      offer(x0, x1, y0, y1, z);
      cyc();
      prim_valid = 1'b0;
      while (m_busy) cyc();
   endtask

   task automatic full_upd(int tx, int ty, int z, bit full);
      upd_valid = 1'b1; upd_full = full;
      upd_tx = 4'(tx); upd_ty = 3'(ty); upd_zmax = 16'(z);
      cyc();
      upd_valid = 1'b0; upd_full = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_2024));
      for (int i = 0; i < NT; i++) m_dep[i] = FAR;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tag = "R1";
      cmp("reset tile_valid", int'(tile_valid), 0);
      cmp("reset prim_ready", int'(prim_ready), 1);
      // R1: whole screen survives just nearer than farthest, culled at farthest
      run_prim(0, 63, 0, 15, FAR - 1);
      tag = "R5";
      run_prim(0, 63, 0, 15, FAR);

      // R2: box footprints, including a single pixel and a box across tile edges
      tag = "R2";
      run_prim(3, 4, 1, 2, 10);
      run_prim(7, 7, 0, 0, 10);
      run_prim(60, 63, 14, 15, 10);

      // R3 / R4: a wide walk checks ordering and ready timing each cycle
      tag = "R3";
      run_prim(8, 27, 4, 9, 1);
      tag = "R4";
      run_prim(0, 0, 0, 0, 1);

      // R6: full update lowers, equal depth then culls, a higher update is ignored
      tag = "R6";
      full_upd(2, 1, 100, 1'b1);
      run_prim(8, 11, 2, 3, 100);
      run_prim(8, 11, 2, 3, 99);
      full_upd(2, 1, 200, 1'b1);
      run_prim(8, 11, 2, 3, 150);

      // R7: partial update must not lower the tile
      tag = "R7";
      full_upd(3, 1, 10, 1'b0);
      run_prim(12, 15, 2, 3, 50);

      // R8: clear together with an update of the same tile
      tag = "R8";
      clr = 1'b1;
      full_upd(2, 1, 5, 1'b1);
      clr = 1'b0;
      run_prim(8, 11, 2, 3, 100);

      // R9: update of the tile under test in its test cycle
      tag = "R9";
      offer(0, 15, 0, 1, 500);
      cyc();
      prim_valid = 1'b0;
      cyc();
      cyc();
      full_upd(2, 0, 100, 1'b1);
      cyc();
      run_prim(8, 11, 0, 1, 500);

      // R10: a different box held during a walk is ignored until ready
      tag = "R10";
      offer(0, 7, 0, 1, 2);
      cyc();
      offer(40, 47, 8, 9, 3);
      while (m_busy) cyc();
      prim_valid = 1'b0;
      cyc();
      while (m_busy) cyc();

      // random mix of offers, updates and clears
      tag = "R5";
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 3) == 0) begin
            int x0 = $urandom_range(0, 63);
            int y0 = $urandom_range(0, 15);
            int x1 = x0 + $urandom_range(0, 9);
            int y1 = y0 + $urandom_range(0, 3);
            if (x1 > 63) x1 = 63;
            if (y1 > 15) y1 = 15;
            offer(x0, x1, y0, y1, ($urandom_range(0, 7) == 0) ? FAR : $urandom_range(0, 65535));
         end else prim_valid = 1'b0;
         upd_valid = ($urandom_range(0, 2) == 0);
         upd_full  = ($urandom_range(0, 1) == 0);
         upd_tx    = 4'($urandom_range(0, 15));
         upd_ty    = 3'($urandom_range(0, 7));
         upd_zmax  = 16'($urandom_range(0, 65535));
         clr       = ($urandom_range(0, 199) == 0);
         cyc();
      end
      prim_valid = 1'b0; upd_valid = 1'b0; clr = 1'b0;
      while (m_busy) cyc();
      summary();
      $finish;
   end
endmodule